// File: doc/BRIEF.md
# Program Memory Byte Fetch Unit

This unit carries out the instruction that reads a single constant byte out of program memory. Program memory is organised as 16-bit words, while the pointer that names the byte, held in the register pair r31:r30 and called Z here, is a byte address. The unit turns that byte address into a word read, picks the low or the high byte of the returned word from the pointer's least significant bit, and writes the byte to a destination register. In one of its forms it then adds one to the full 16-bit pointer and writes it back.

The unit sits beside the core's decoder. A decoded instruction word is offered together with a valid strobe. If the word is one of the three recognised encodings and the unit is idle, it is taken, the current pointer value is captured, and the unit runs a fixed three-cycle sequence: a word read, then the byte write to the register file, then completion with the optional pointer write. Busy covers all three cycles and nothing new is taken until it drops. The post-increment form aimed at r30 or r31 has no defined architectural result. The unit writes the byte first, then overwrites the pair with the original pointer plus one, and raises a flag for the whole operation. No status flag is produced or altered.

Top module: `pmem_byte_fetch`

## Requirements
- R1: Three encodings are taken: 16'h95C8 loads into register 0, pattern 1001_000d_dddd_0100 loads into register ddddd (bits 8:4), and pattern 1001_000d_dddd_0101 loads into register ddddd and also increments the pointer. Any other word is ignored.
- R2: In the first busy cycle the unit raises the memory read strobe and drives the word address with bits 15:1 of the pointer captured at acceptance.
- R3: In the second busy cycle the unit writes one byte to the destination: bits 7:0 of the returned word when pointer bit 0 is 0, and bits 15:8 when it is 1. The memory is synchronous, so the word arrives one cycle after the read strobe.
- R4: Busy is high for exactly three cycles after acceptance, and done pulses in the third of them.
- R5: The post-increment form writes the captured pointer plus one, modulo 2^16, to the pointer pair in the third busy cycle. 16'hFFFF becomes 16'h0000.
- R6: The two forms without increment never write the pointer pair.
- R7: For the post-increment form with destination 30 or 31, the undefined-combination flag is high for all three busy cycles. The byte is written in the second cycle and the incremented pointer in the third. The flag is low at all other times.
- R8: While busy, the instruction input and the pointer input are ignored. The operation in progress completes with its captured values and no second operation starts.
- R9: After reset the unit is idle, with busy, done, the read strobe, both write enables and the flag all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction word is offered |
| instWord | input | 16 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| undefFlag | output | 1 | Operation is the undefined pointer-destination combination |
| zIn | input | ADDR_W | Current pointer value read from r31:r30 |
| pmemRd | output | 1 | Program memory read strobe |
| pmemAddr | output | ADDR_W-1 | Program memory word address |
| pmemData | input | WORD_W | Program memory word, valid the cycle after the strobe |
| rfWrEn | output | 1 | Destination register write enable |
| rfWrAddr | output | 5 | Destination register index |
| rfWrData | output | BYTE_W | Byte written to the destination |
| zWrEn | output | 1 | Pointer pair write enable |
| zWrData | output | ADDR_W | New pointer value for r31:r30 |

## Verification
The assertions check several things on every cycle: the bound on the busy window, that done falls on its third cycle, that a byte write follows a read one cycle earlier, that the word address is the captured pointer with its low bit dropped, that a pointer write comes only after a byte write and carries the value taken three cycles earlier plus one, and that the two writes never coincide. Only the bench scenarios can show which byte lane was chosen for a given memory word, that each encoding selects the right destination or none, the wrap from 16'hFFFF, and that noise on the inputs during an operation changes nothing.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  localparam int REG_AW = 5;

  localparam logic [15:0] OPC_IMPLIED = 16'h95C8;
  localparam logic [6:0]  OPC_HI7     = 7'b1001000;
  localparam logic [3:0]  NIB_PLAIN   = 4'b0100;
  localparam logic [3:0]  NIB_INC     = 4'b0101;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FINISH = 2'd3
  } pfuState_e;

  typedef struct packed {
    logic              valid;
    logic [REG_AW-1:0] dest;
    logic              postInc;
    logic              undef;
  } pfuDec_t;

  typedef struct packed {
    logic capture;
    logic memRd;
    logic byteWr;
    logic finish;
    logic active;
  } pfuStrobe_t;

endpackage

// File: rtl/pfu_decode.sv
module pfu_decode
  import pfu_pkg::*;
(
  input  logic [15:0] instWord,
  output pfuDec_t     dec
);

  logic isImplied;
  logic isPlain;
  logic isInc;

  always_comb begin
    isImplied = (instWord == OPC_IMPLIED);
    isPlain   = (instWord[15:9] == OPC_HI7) && (instWord[3:0] == NIB_PLAIN);
    isInc     = (instWord[15:9] == OPC_HI7) && (instWord[3:0] == NIB_INC);
  end

  always_comb begin
    dec = '0;
    if (isImplied) begin
      dec.valid = 1'b1;
      dec.dest  = '0;
    end else if (isPlain || isInc) begin
      dec.valid   = 1'b1;
      dec.dest    = instWord[8:4];
      dec.postInc = isInc;
    end
    dec.undef = dec.postInc && (dec.dest[REG_AW-1:1] == '1);
  end

endmodule

// File: rtl/pfu_ctrl.sv
module pfu_ctrl
  import pfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic       decValid,
  output pfuStrobe_t stb,
  output logic       busy,
  output logic       done
);

  pfuState_e state;
  pfuState_e stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && instValid && decValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_FETCH;
      ST_FETCH:  stateNext = ST_WRITE;
      ST_WRITE:  stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb         = '0;
    stb.capture = accept;
    stb.memRd   = (state == ST_FETCH);
    stb.byteWr  = (state == ST_WRITE);
    stb.finish  = (state == ST_FINISH);
    stb.active  = (state != ST_IDLE);
  end

  assign busy = stb.active;
  assign done = stb.finish;

endmodule

// File: rtl/pfu_datapath.sv
module pfu_datapath
  import pfu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfuStrobe_t        stb,
  input  pfuDec_t           dec,
  input  logic [ADDR_W-1:0] zIn,
  input  logic [WORD_W-1:0] pmemData,
  output logic              pmemRd,
  output logic [ADDR_W-2:0] pmemAddr,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [BYTE_W-1:0] rfWrData,
  output logic              zWrEn,
  output logic [ADDR_W-1:0] zWrData,
  output logic              undefFlag
);

  localparam int LANES     = WORD_W / BYTE_W;
  localparam int LANE_BITS = $clog2(LANES);

  logic [ADDR_W-1:0] zReg;
  logic [REG_AW-1:0] destReg;
  logic              incReg;
  logic              undefReg;
  logic [BYTE_W-1:0] laneArr [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zReg     <= '0;
      destReg  <= '0;
      incReg   <= 1'b0;
      undefReg <= 1'b0;
    end else if (stb.capture) begin
      zReg     <= zIn;
      destReg  <= dec.dest;
      incReg   <= dec.postInc;
      undefReg <= dec.undef;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneArr[g] = pmemData[g*BYTE_W +: BYTE_W];
  end

  assign pmemRd    = stb.memRd;
  assign pmemAddr  = zReg[ADDR_W-1:LANE_BITS];
  assign rfWrEn    = stb.byteWr;
  assign rfWrAddr  = destReg;
  assign rfWrData  = laneArr[zReg[LANE_BITS-1:0]];
  assign zWrEn     = stb.finish && incReg;
  assign zWrData   = zReg + 1'b1;
  assign undefFlag = stb.active && undefReg;

endmodule

// File: rtl/pmem_byte_fetch.sv
module pmem_byte_fetch
  import pfu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  output logic              busy,
  output logic              done,
  output logic              undefFlag,
  input  logic [ADDR_W-1:0] zIn,
  output logic              pmemRd,
  output logic [ADDR_W-2:0] pmemAddr,
  input  logic [WORD_W-1:0] pmemData,
  output logic              rfWrEn,
  output logic [4:0]        rfWrAddr,
  output logic [BYTE_W-1:0] rfWrData,
  output logic              zWrEn,
  output logic [ADDR_W-1:0] zWrData
);

  pfuDec_t    dec;
  pfuStrobe_t stb;

  pfu_decode u_dec (
    .instWord (instWord),
    .dec      (dec)
  );

  pfu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .decValid  (dec.valid),
    .stb       (stb),
    .busy      (busy),
    .done      (done)
  );

  pfu_datapath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .dec       (dec),
    .zIn       (zIn),
    .pmemData  (pmemData),
    .pmemRd    (pmemRd),
    .pmemAddr  (pmemAddr),
    .rfWrEn    (rfWrEn),
    .rfWrAddr  (rfWrAddr),
    .rfWrData  (rfWrData),
    .zWrEn     (zWrEn),
    .zWrData   (zWrData),
    .undefFlag (undefFlag)
  );

endmodule

// File: rtl/pfu_checker.sv
module pfu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              undefFlag,
  input logic [ADDR_W-1:0] zIn,
  input logic              pmemRd,
  input logic [ADDR_W-2:0] pmemAddr,
  input logic              rfWrEn,
  input logic              zWrEn,
  input logic [ADDR_W-1:0] zWrData
);

  logic [2:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 3'd1;
    else           busyCnt <= '0;
  end

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < 3'd3));

  p_done_third_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && busyCnt == 3'd2));

  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_read_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> $past(pmemRd));

  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    pmemRd |-> (pmemAddr == $past(zIn[ADDR_W-1:1])));

  p_zwr_after_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    zWrEn |-> ($past(rfWrEn) && done));

  p_zwr_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    zWrEn |-> (zWrData == $past(zIn, 3) + 1'b1));

  p_no_dual_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWrEn && zWrEn));

  p_undef_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> busy);

endmodule

bind pmem_byte_fetch pfu_checker #(.ADDR_W(ADDR_W)) u_pfu_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .undefFlag (undefFlag),
  .zIn       (zIn),
  .pmemRd    (pmemRd),
  .pmemAddr  (pmemAddr),
  .rfWrEn    (rfWrEn),
  .zWrEn     (zWrEn),
  .zWrData   (zWrData)
);

// File: tb/pmem_byte_fetch_tb_top.sv
module pmem_byte_fetch_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] instWord = '0;
  logic [15:0] zIn = '0;
  logic        busy, done, undefFlag, pmemRd, rfWrEn, zWrEn;
  logic [14:0] pmemAddr;
  logic [15:0] pmemData;
  logic [4:0]  rfWrAddr;
  logic [7:0]  rfWrData;
  logic [15:0] zWrData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_byte_fetch dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .busy(busy), .done(done), .undefFlag(undefFlag), .zIn(zIn),
    .pmemRd(pmemRd), .pmemAddr(pmemAddr), .pmemData(pmemData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .zWrEn(zWrEn), .zWrData(zWrData)
  );

  function automatic logic [15:0] memWord(input logic [14:0] a);
    logic [31:0] t;
    t = ({17'd0, a} * 32'd40503) ^ 32'h0000A5C3;
    return t[15:0];
  endfunction

  always @(posedge clk) begin
    if (pmemRd) pmemData <= memWord(pmemAddr);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Presents one instruction and compares every cycle of the operation.
  task automatic runOp(input logic [15:0] inst, input logic [15:0] z,
                       input int dest, input bit inc, input bit noise);
    int expByte;
    logic [15:0] w;
    bit und;
    w = memWord(z[15:1]);
    expByte = z[0] ? int'(w[15:8]) : int'(w[7:0]);
    und = inc && (dest >= 30);
    instWord = inst; zIn = z; instValid = 1'b1;
    @(negedge clk);
    if (noise) begin instWord = 16'h9015; zIn = ~z; end
    else instValid = 1'b0;
    chk(busy && pmemRd && !rfWrEn && !zWrEn && !done, "R2 fetch cycle strobes", {busy, pmemRd, rfWrEn, zWrEn, done}, 5'b11000);
    chk(pmemAddr == z[15:1], "R2 word address", pmemAddr, z[15:1]);
    chk(undefFlag == und, "R7 flag cycle1", undefFlag, und);
    @(negedge clk);
    chk(busy && rfWrEn && !zWrEn && !done && !pmemRd, "R4 write cycle strobes", {busy, rfWrEn, zWrEn, done}, 4'b1100);
    chk(rfWrAddr == dest, "R1 destination", rfWrAddr, dest);
    chk(rfWrData == expByte, "R3 lane byte", rfWrData, expByte);
    chk(undefFlag == und, "R7 flag cycle2", undefFlag, und);
    @(negedge clk);
    instValid = 1'b0;
    chk(busy && done && !rfWrEn, "R4 done on third cycle", {busy, done, rfWrEn}, 3'b110);
    chk(zWrEn == inc, inc ? "R5 pointer write" : "R6 no pointer write", zWrEn, inc);
    if (inc) chk(zWrData == 16'(z + 16'd1), "R5 incremented pointer", zWrData, 16'(z + 16'd1));
    chk(undefFlag == und, "R7 flag cycle3", undefFlag, und);
    @(negedge clk);
    chk(!busy && !done && !rfWrEn && !zWrEn && !pmemRd && !undefFlag, noise ? "R8 no second op" : "R4 back to idle",
        {busy, done, rfWrEn, zWrEn, pmemRd, undefFlag}, 0);
  endtask

  task automatic tryIgnored(input logic [15:0] inst);
    instWord = inst; zIn = 16'h1234; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    chk(!busy && !pmemRd, "R1 foreign word ignored", {busy, pmemRd}, 0);
    @(negedge clk);
    chk(!busy && !rfWrEn && !zWrEn, "R1 foreign word no writes", {busy, rfWrEn, zWrEn}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pmemRd && !rfWrEn && !zWrEn && !undefFlag, "R9 reset state",
        {busy, done, pmemRd, rfWrEn, zWrEn, undefFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R9 idle after reset", busy, 0);
    runOp(16'h95C8, 16'h0010, 0, 1'b0, 1'b0);
    runOp(16'h9054, 16'h1235, 5, 1'b0, 1'b0);
    runOp(16'h9115, 16'h00FF, 17, 1'b1, 1'b0);
    runOp(16'h9025, 16'hFFFF, 2, 1'b1, 1'b0);
    runOp(16'h91E5, 16'h4000, 30, 1'b1, 1'b0);
    runOp(16'h91F5, 16'h7FFF, 31, 1'b1, 1'b0);
    runOp(16'h91E4, 16'h0302, 30, 1'b0, 1'b0);
    runOp(16'h90A4, 16'hABCD, 10, 1'b0, 1'b1);
    runOp(16'h9035, 16'h2222, 3, 1'b1, 1'b1);
    tryIgnored(16'h9006);
    tryIgnored(16'h95C9);
    tryIgnored(16'h9245);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule